// File: doc/BRIEF.md
# FFT block handshake controller

This controller sequences one block-based 64-point transform engine. It decides when an input block is taken, tracks how long the engine stays occupied, tells the consumer when a result is ready and then produces the read addresses and framing flags for a 64-sample output burst. A free-running cycle counter stands in for the compute passes. The butterfly datapath, the twiddle source and the sample memory sit outside the block and follow the write and read strobes it drives.

Configuration is taken only under a synchronous clear: a direction bit and a 3-bit scaling code. The code is also expanded into the per-pass right-shift amounts the arithmetic neighbour needs. Loading overlaps the first compute pass and unloading may overlap the last one, so with output enable held high a new block can be accepted every 448 cycles.

Top module: `fft_handshake_ctrl`

## Requirements
- R1: While the asynchronous active-low reset is low, direction reads 0 (forward), the scaling code reads 7, and loading, busy, done, output valid, output start, read enable and the overflow flag are all low.
- R2: A cycle with clear high returns loading, busy, done, overflow and the output burst to idle and latches the direction and scaling inputs. In any other cycle those two inputs have no effect on the direction and scaling outputs.
- R3: Loading goes high in the cycle after an accepted start strobe, stays high for 63 cycles, and is low again once the 64th sample has been taken (the 64th edge counting the start edge).
- R4: Write enable is high in the start cycle with write address 0, and in every loading cycle; there the address is the index of the sample taken at the next edge, counting 1 to 63 in natural order.
- R5: Busy rises together with loading and stays high until it drops 447 cycles after the start edge, so a start strobe exactly 448 edges after the previous accepted one is taken.
- R6: A start strobe sampled while loading or busy is high is ignored: the loading, busy and overflow timing of the running block does not change.
- R7: Done rises 433 edges after the start edge and falls after the first edge at which output enable is sampled high together with done.
- R8: Starting in the cycle after that edge, read enable is high for 64 cycles with read address 0 to 63 in natural order.
- R9: Output valid is high for 64 cycles starting two cycles after the edge that accepted output enable; output start is high only in the first of those cycles. With output enable held high all the time, unloading starts by itself.
- R10: The overflow flag is cleared by an accepted start, set by an overflow report sampled while busy and then held until the next accepted start; a report sampled while not busy is ignored.
- R11: The shift plan output carries pass 1 in bits 1:0, pass 2 in bits 3:2 and pass 3 in bits 5:4; codes 0 to 7 give pass 1 shifts 0,1,1,2,2,2,3,3, pass 2 shifts 0,0,1,1,1,2,2,2 and pass 3 shifts 0,0,0,0,1,1,1,2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear and configuration strobe |
| cfgInverseIn | input | 1 | Direction to latch under clear: 0 forward, 1 inverse |
| cfgScaleIn | input | 3 | Scaling code to latch under clear |
| inStart | input | 1 | Input block start strobe, marks sample 0 |
| outEnable | input | 1 | Permission to unload a finished result |
| ovfIn | input | 1 | Overflow report from the arithmetic |
| loading | output | 1 | Input block being taken |
| busy | output | 1 | Engine occupied, no new block accepted |
| done | output | 1 | Result ready for unloading |
| wrEn | output | 1 | Sample memory write enable |
| wrAddr | output | 6 | Sample memory write address |
| rdEn | output | 1 | Sample memory read enable |
| rdAddr | output | 6 | Sample memory read address |
| outStart | output | 1 | First output sample marker |
| outValid | output | 1 | Output sample valid |
| ovfFlag | output | 1 | Sticky overflow flag of the current block |
| modeInverse | output | 1 | Latched direction |
| scaleCode | output | 3 | Latched scaling code |
| shiftPlan | output | 6 | Right-shift amount for each of the three passes |

## Verification
The bench builds the block with its default parameters: 64 samples, a 448-cycle block period, done at 433 and a two-cycle output latency. These values bring the full schedule within reach, including the done-to-enable handshake with enable held, exactly at the done edge and late, a start strobe one edge before and exactly at the end of busy, and an output burst that overlaps the loading of the next block. Random enable edges and overflow report positions, both inside and outside busy, are mixed with directed blocks, and every scaling code is programmed under clear and then challenged without it.

// File: rtl/fftc_pkg.sv
package fftc_pkg;

  typedef struct packed {
    logic takeBlock;
    logic beginUnload;
  } ctrl_strobe_t;

  // Per-pass shift amounts, packed {pass3, pass2, pass1}
  function automatic logic [5:0] shift_plan(input logic [2:0] code);
    logic [1:0] p1, p2, p3;
    case (code)
      3'd0:    begin p1 = 2'd0; p2 = 2'd0; p3 = 2'd0; end
      3'd1:    begin p1 = 2'd1; p2 = 2'd0; p3 = 2'd0; end
      3'd2:    begin p1 = 2'd1; p2 = 2'd1; p3 = 2'd0; end
      3'd3:    begin p1 = 2'd2; p2 = 2'd1; p3 = 2'd0; end
      3'd4:    begin p1 = 2'd2; p2 = 2'd1; p3 = 2'd1; end
      3'd5:    begin p1 = 2'd2; p2 = 2'd2; p3 = 2'd1; end
      3'd6:    begin p1 = 2'd3; p2 = 2'd2; p3 = 2'd1; end
      default: begin p1 = 2'd3; p2 = 2'd2; p3 = 2'd2; end
    endcase
    return {p3, p2, p1};
  endfunction

endpackage

// File: rtl/fftc_ctrl.sv
module fftc_ctrl
  import fftc_pkg::*;
#(
  parameter int N            = 64,
  parameter int BLOCK_CYCLES = 7 * N,
  parameter int DONE_AT      = 433
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   clr,
  input  logic                   inStart,
  input  logic                   outEnable,
  input  logic                   ovfIn,
  input  logic                   unloadActive,
  output logic                   loading,
  output logic                   busy,
  output logic                   done,
  output logic                   ovfFlag,
  output logic                   wrEn,
  output logic [$clog2(N)-1:0]   wrAddr,
  output ctrl_strobe_t           strobe
);

  localparam int AW    = $clog2(N);
  localparam int CNT_W = $clog2(BLOCK_CYCLES);
  localparam logic [CNT_W-1:0] LOAD_END = CNT_W'(N - 1);
  localparam logic [CNT_W-1:0] BUSY_END = CNT_W'(BLOCK_CYCLES - 1);
  localparam logic [CNT_W-1:0] DONE_CNT = CNT_W'(DONE_AT);

  logic [CNT_W-1:0] cycleCnt;
  logic takeBlock, beginUnload;

  assign takeBlock   = inStart & ~loading & ~busy & ~clr;
  assign beginUnload = done & outEnable & ~unloadActive & ~clr;

  assign strobe.takeBlock   = takeBlock;
  assign strobe.beginUnload = beginUnload;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loading  <= 1'b0;
      busy     <= 1'b0;
      done     <= 1'b0;
      ovfFlag  <= 1'b0;
      cycleCnt <= '0;
    end else if (clr) begin
      loading  <= 1'b0;
      busy     <= 1'b0;
      done     <= 1'b0;
      ovfFlag  <= 1'b0;
      cycleCnt <= '0;
    end else begin
      if (takeBlock) begin
        loading  <= 1'b1;
        busy     <= 1'b1;
        cycleCnt <= CNT_W'(1);
      end else if (busy) begin
        cycleCnt <= cycleCnt + 1'b1;
        if (cycleCnt == LOAD_END) loading <= 1'b0;
        if (cycleCnt == BUSY_END) busy    <= 1'b0;
      end

      if (busy && cycleCnt == DONE_CNT) done <= 1'b1;
      else if (beginUnload)             done <= 1'b0;

      if (takeBlock)          ovfFlag <= 1'b0;
      else if (busy && ovfIn) ovfFlag <= 1'b1;
    end
  end

  assign wrEn   = takeBlock | loading;
  assign wrAddr = loading ? cycleCnt[AW-1:0] : '0;

  // R5: loading is a sub-window of busy
  p_load_in_busy_r5: assert property (@(posedge clk) disable iff (!rstN)
    loading |-> busy);

  // R6: a strobe during compute does not restart loading
  p_start_ignored_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !loading && inStart && !clr) |=> !loading);

  // R7: accepted enable drops done
  p_done_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    (done && outEnable && !clr) |=> !done);

  // R10: overflow flag only leaves on a start strobe or clear
  p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !inStart && !clr) |=> ovfFlag);

  // R4: natural write order while loading
  p_wr_order_r4: assert property (@(posedge clk) disable iff (!rstN)
    (loading && !clr) |=> (!loading || wrAddr == $past(wrAddr) + 1'b1));

endmodule

// File: rtl/fftc_dpath.sv
module fftc_dpath
  import fftc_pkg::*;
#(
  parameter int N       = 64,
  parameter int OUT_LAT = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   clr,
  input  logic                   cfgInverseIn,
  input  logic [2:0]             cfgScaleIn,
  input  ctrl_strobe_t           strobe,
  output logic                   modeInverse,
  output logic [2:0]             scaleCode,
  output logic [5:0]             shiftPlan,
  output logic                   rdEn,
  output logic [$clog2(N)-1:0]   rdAddr,
  output logic                   unloadActive,
  output logic                   outStart,
  output logic                   outValid
);

  localparam int AW = $clog2(N);
  localparam logic [AW-1:0] RD_END = AW'(N - 1);

  logic           reading;
  logic [AW-1:0]  rdCnt;
  logic [OUT_LAT-1:0] validPipe, firstPipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeInverse <= 1'b0;
      scaleCode   <= 3'd7;
    end else if (clr) begin
      modeInverse <= cfgInverseIn;
      scaleCode   <= cfgScaleIn;
    end
  end

  assign shiftPlan = shift_plan(scaleCode);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reading <= 1'b0;
      rdCnt   <= '0;
    end else if (clr) begin
      reading <= 1'b0;
      rdCnt   <= '0;
    end else if (strobe.beginUnload) begin
      reading <= 1'b1;
      rdCnt   <= '0;
    end else if (reading) begin
      if (rdCnt == RD_END) reading <= 1'b0;
      rdCnt <= rdCnt + 1'b1;
    end
  end

  assign rdEn         = reading;
  assign rdAddr       = rdCnt;
  assign unloadActive = reading;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validPipe <= '0;
      firstPipe <= '0;
    end else if (clr) begin
      validPipe <= '0;
      firstPipe <= '0;
    end else begin
      validPipe <= OUT_LAT'({validPipe, reading});
      firstPipe <= OUT_LAT'({firstPipe, reading && rdCnt == '0});
    end
  end

  assign outValid = validPipe[OUT_LAT-1];
  assign outStart = firstPipe[OUT_LAT-1];

  // R9: first-sample marker only on a valid sample
  p_first_valid_r9: assert property (@(posedge clk) disable iff (!rstN)
    outStart |-> outValid);

  // R9: valid trails the read strobe by the output latency
  p_valid_lat_r9: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !$past(clr)) |-> $past(rdEn, OUT_LAT));

  // R2: configuration moves only under clear
  p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !clr |=> ($stable(modeInverse) && $stable(scaleCode)));

endmodule

// File: rtl/fft_handshake_ctrl.sv
module fft_handshake_ctrl
  import fftc_pkg::*;
#(
  parameter int N            = 64,
  parameter int BLOCK_CYCLES = 7 * N,
  parameter int DONE_AT      = 433,
  parameter int OUT_LAT      = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 clr,
  input  logic                 cfgInverseIn,
  input  logic [2:0]           cfgScaleIn,
  input  logic                 inStart,
  input  logic                 outEnable,
  input  logic                 ovfIn,
  output logic                 loading,
  output logic                 busy,
  output logic                 done,
  output logic                 wrEn,
  output logic [$clog2(N)-1:0] wrAddr,
  output logic                 rdEn,
  output logic [$clog2(N)-1:0] rdAddr,
  output logic                 outStart,
  output logic                 outValid,
  output logic                 ovfFlag,
  output logic                 modeInverse,
  output logic [2:0]           scaleCode,
  output logic [5:0]           shiftPlan
);

  ctrl_strobe_t strobe;
  logic unloadActive;

  fftc_ctrl #(.N(N), .BLOCK_CYCLES(BLOCK_CYCLES), .DONE_AT(DONE_AT)) u_ctrl (
    .clk(clk), .rstN(rstN), .clr(clr),
    .inStart(inStart), .outEnable(outEnable), .ovfIn(ovfIn),
    .unloadActive(unloadActive),
    .loading(loading), .busy(busy), .done(done), .ovfFlag(ovfFlag),
    .wrEn(wrEn), .wrAddr(wrAddr), .strobe(strobe)
  );

  fftc_dpath #(.N(N), .OUT_LAT(OUT_LAT)) u_dpath (
    .clk(clk), .rstN(rstN), .clr(clr),
    .cfgInverseIn(cfgInverseIn), .cfgScaleIn(cfgScaleIn), .strobe(strobe),
    .modeInverse(modeInverse), .scaleCode(scaleCode), .shiftPlan(shiftPlan),
    .rdEn(rdEn), .rdAddr(rdAddr), .unloadActive(unloadActive),
    .outStart(outStart), .outValid(outValid)
  );

endmodule

// File: tb/sim_fft_handshake_ctrl.sv
module sim_fft_handshake_ctrl;

  logic clk = 1'b0;
  logic rstN, clr, cfgInverseIn, inStart, outEnable, ovfIn;
  logic [2:0] cfgScaleIn;
  logic loading, busy, done, wrEn, rdEn, outStart, outValid, ovfFlag, modeInverse;
  logic [5:0] wrAddr, rdAddr, shiftPlan;
  logic [2:0] scaleCode;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  fft_handshake_ctrl u0 (
    .clk(clk), .rstN(rstN), .clr(clr), .cfgInverseIn(cfgInverseIn),
    .cfgScaleIn(cfgScaleIn), .inStart(inStart), .outEnable(outEnable),
    .ovfIn(ovfIn), .loading(loading), .busy(busy), .done(done),
    .wrEn(wrEn), .wrAddr(wrAddr), .rdEn(rdEn), .rdAddr(rdAddr),
    .outStart(outStart), .outValid(outValid), .ovfFlag(ovfFlag),
    .modeInverse(modeInverse), .scaleCode(scaleCode), .shiftPlan(shiftPlan)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int expPlan(input int code);
    int p1 [8] = '{0, 1, 1, 2, 2, 2, 3, 3};
    int p2 [8] = '{0, 0, 1, 1, 1, 2, 2, 2};
    int p3 [8] = '{0, 0, 0, 0, 1, 1, 1, 2};
    return p3[code] * 16 + p2[code] * 4 + p1[code];
  endfunction

  // One block from start strobe; k counts cycles after the start edge
  task automatic runBlock(input int enEdge, input int ovEdge, input int ovIdle, input bit b2b);
    int u, lim, eRdA, eWrA;
    bit eLoad, eBusy, eDone, eRd, eV, eS, eOvf, eWr;
    u   = (enEdge > 434) ? enEdge : 434;
    lim = u + 70;
    inStart = 1'b1;
    #1;
    chk("R4", "wrEn at start", int'(wrEn), 1);
    chk("R4", "wrAddr at start", int'(wrAddr), 0);
    step();
    for (int k = 0; k <= lim; k++) begin
      inStart   = (k + 1 == 30) || (k + 1 == 200) || (b2b && (k + 1 == 447 || k + 1 == 448));
      outEnable = (k + 1 >= enEdge);
      ovfIn     = (ovEdge > 0 && k + 1 == ovEdge) || (!b2b && ovIdle > 0 && k + 1 == ovIdle);
      #1;
      eLoad = (k < 63) || (b2b && k >= 448 && k < 511);
      eBusy = (k < 447) || (b2b && k >= 448);
      eDone = (k >= 433) && (k < u);
      eRd   = (k >= u) && (k < u + 64);
      eRdA  = k - u;
      eV    = (k >= u + 2) && (k < u + 66);
      eS    = (k == u + 2);
      eOvf  = (ovEdge > 0) && (k >= ovEdge) && !(b2b && k >= 448);
      eWr   = eLoad || (b2b && k == 447);
      eWrA  = (b2b && k == 447) ? 0 : ((k < 63) ? k + 1 : k - 448 + 1);
      chk("R3", "loading", int'(loading), int'(eLoad));
      chk("R5", "busy", int'(busy), int'(eBusy));
      chk("R7", "done", int'(done), int'(eDone));
      chk("R8", "rdEn", int'(rdEn), int'(eRd));
      if (eRd) chk("R8", "rdAddr", int'(rdAddr), eRdA);
      chk("R9", "outValid", int'(outValid), int'(eV));
      chk("R9", "outStart", int'(outStart), int'(eS));
      chk("R10", "ovfFlag", int'(ovfFlag), int'(eOvf));
      chk("R4", "wrEn", int'(wrEn), int'(eWr));
      if (eWr) chk("R4", "wrAddr", int'(wrAddr), eWrA);
      step();
    end
    inStart = 1'b0; outEnable = 1'b0; ovfIn = 1'b0;
  endtask

  initial begin
    int seedDummy;
    bit inv;
    int ovE, ovI;
    seedDummy = $urandom(32'd4711);
    rstN = 1'b0; clr = 1'b0; cfgInverseIn = 1'b1; cfgScaleIn = 3'd2;
    inStart = 1'b0; outEnable = 1'b0; ovfIn = 1'b0;
    step(); step();
    // R1: default mode under reset
    chk("R1", "modeInverse", int'(modeInverse), 0);
    chk("R1", "scaleCode", int'(scaleCode), 7);
    chk("R1", "shiftPlan", int'(shiftPlan), expPlan(7));
    chk("R1", "flags", int'({loading, busy, done, outValid, outStart, rdEn, ovfFlag}), 0);
    rstN = 1'b1;
    step();
    chk("R1", "scaleCode after release", int'(scaleCode), 7);

    // R2 / R11: program each code, then try to change without clear
    for (int c = 0; c < 8; c++) begin
      inv = 1'($urandom % 2);
      cfgScaleIn = 3'(c); cfgInverseIn = inv; clr = 1'b1;
      step();
      clr = 1'b0;
      chk("R2", "modeInverse latched", int'(modeInverse), int'(inv));
      chk("R2", "scaleCode latched", int'(scaleCode), c);
      chk("R11", "shiftPlan", int'(shiftPlan), expPlan(c));
      cfgScaleIn = ~3'(c); cfgInverseIn = ~inv;
      step();
      chk("R2", "modeInverse held", int'(modeInverse), int'(inv));
      chk("R2", "scaleCode held", int'(scaleCode), c);
    end
    cfgScaleIn = 3'd3; cfgInverseIn = 1'b1; clr = 1'b1;
    step();
    clr = 1'b0;

    // Directed: enable held (R9 automatic unload), overflow early, idle report ignored (R10)
    runBlock(1, 20, 470, 1'b0);
    // Directed: late enable
    runBlock(480, 0, 460, 1'b0);
    // Directed: enable exactly at the first edge done is seen
    runBlock(434, 447, 449, 1'b0);
    // Directed: back-to-back, strobe one edge early ignored, exact edge taken (R5, R6)
    runBlock(1, 300, 0, 1'b1);
    clr = 1'b1;
    step();
    clr = 1'b0;
    chk("R2", "clear flags", int'({loading, busy, done, outValid, rdEn, ovfFlag}), 0);
    chk("R2", "clear keeps programmed code", int'(scaleCode), 3);

    // Random blocks
    for (int b = 0; b < 3; b++) begin
      ovE = ($urandom % 2) ? int'($urandom_range(1, 447)) : 0;
      ovI = int'($urandom_range(449, 500));
      runBlock(int'($urandom_range(300, 500)), ovE, ovI, 1'b0);
    end

    // Clear in the middle of a block, then a fresh start is taken
    inStart = 1'b1; ovfIn = 1'b0;
    step();
    inStart = 1'b0; ovfIn = 1'b1;
    step();
    ovfIn = 1'b0;
    repeat (100) step();
    chk("R10", "ovf set mid block", int'(ovfFlag), 1);
    clr = 1'b1;
    step();
    clr = 1'b0;
    chk("R2", "mid-block clear", int'({loading, busy, done, ovfFlag}), 0);
    inStart = 1'b1;
    step();
    inStart = 1'b0;
    chk("R3", "start after clear", int'(loading), 1);
    chk("R5", "busy after clear", int'(busy), 1);
    clr = 1'b1;
    step();
    clr = 1'b0;

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule